// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a register-programmed master for the two-wire PHY management bus. It builds both frame formats: the single-frame format with a 5-bit register field, and the extended format in which a separate frame carries the register address to a device within the PHY. Software loads an operation word, an address word and a data word, then writes a start bit. The block serializes the frame on MDIO, clocked by a divided-down MDC. On reads it releases the line from the turnaround onward and collects the PHY's 16 reply bits. The start bit reads back as a busy flag until the frame has been shifted out completely.

A single frame per start is sent. An extended-format read or write takes two starts: an address frame first, then the data frame. Software does this sequencing by polling the busy flag between the two frames.

Top module: `mdio_master`

## Requirements
- R1: After reset the control register (offset 3) reads 0, MDC is low and the MDIO output enable is low.
- R2: A bus write of bit 0 = 1 to offset 3 while idle starts one frame. Offset 3 bit 0 reads 1 while the frame is in progress and reads 0 once the frame is complete.
- R3: A start write while a frame is in progress is ignored: exactly 64 rising MDC edges occur per accepted start.
- R4: Every frame opens with 32 ones. The next two bits are the start field: 01 when operation bit 12 = 0 (short format) and 00 when operation bit 12 = 1 (extended format).
- R5: After the start field come the opcode (operation bits 11:10), the 5-bit PHY address (bits 9:5) and the 5-bit device or register field (bits 4:0), each sent MSB first.
- R6: In short format the 5-bit field is the register number. In extended format it is the device number, and the register number travels only in the address word (offset 1).
- R7: Write frames (any frame that is not a read) send turnaround 10 and then 16 payload bits MSB first. The payload is the data word (offset 0), and MDIO stays driven for all 64 bits.
- R8: An extended-format frame with opcode 00 sends the address word (offset 1) as its 16 payload bits.
- R9: Read frames are short format with opcode 10, or extended format with opcode 1x. On these the output enable drops for the last 18 bit times (turnaround and data). The 16 bits sampled on rising MDC are stored MSB first in the data word, which holds them once busy clears.
- R10: MDC has a period of 2*CLK_DIV_HALF system clocks while busy and stays low while idle. MDIO changes only when MDC falls.
- R11: Offsets 0 and 1 read back their 16-bit contents, and offset 2 reads back the 13-bit operation word. The data word changes only on a bus write to offset 0 or on read completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset: 0 data, 1 address, 2 operation, 3 control |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational from bus_addr) |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The bench attacks the points where the two formats differ. It checks the start field and the address-frame payload: a design that mixed these up would send the data word where the register address belongs, or emit 01 in an extended frame. For reads it checks that the line is released exactly at the turnaround and that the reply is assembled MSB first. An off-by-one in the bit counter would leave the line driven into the PHY's turnaround, or shift the reply by a bit. It also issues a second start in the middle of a frame, which a design that fails to gate the start would answer by restarting or lengthening the frame past 64 MDC edges.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;

  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 64;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;
  localparam int WORD_W     = 16;
  localparam int OP_W       = 13;

  typedef struct packed {
    logic       c45;
    logic [1:0] opc;
    logic [4:0] port;
    logic [4:0] dev;
  } op_t;

  function automatic logic is_read(op_t o);
    return o.c45 ? o.opc[1] : (o.opc == 2'b10);
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(op_t o, logic [WORD_W-1:0] a,
                                                         logic [WORD_W-1:0] d);
    logic [WORD_W-1:0] pay;
    logic [1:0]        st;
    logic [1:0]        ta;
    st  = o.c45 ? 2'b00 : 2'b01;
    pay = (o.c45 && o.opc == 2'b00) ? a : d;
    ta  = 2'b10;
    if (is_read(o)) begin
      ta  = 2'b11;
      pay = '1;
    end
    return {{PRE_BITS{1'b1}}, st, o.opc, o.port, o.dev, ta, pay};
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          wrap;

  assign wrap      = run && (cnt_q == CW'(HALF - 1));
  assign rise_tick = wrap && !mdc_q;
  assign fall_tick = wrap && mdc_q;
  assign mdc       = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
  import mdio_master_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              rd_done,
  input  logic [WORD_W-1:0] rd_word,
  output op_t               op_q,
  output logic [WORD_W-1:0] addr_q,
  output logic [WORD_W-1:0] data_q,
  output logic              start
);
  op_t               op_d;
  logic [WORD_W-1:0] addr_d, data_d;
  logic              wr_data, wr_addr, wr_op, wr_ctl;

  assign wr_data = bus_wr && (bus_addr == 2'd0);
  assign wr_addr = bus_wr && (bus_addr == 2'd1);
  assign wr_op   = bus_wr && (bus_addr == 2'd2);
  assign wr_ctl  = bus_wr && (bus_addr == 2'd3);
  assign start   = wr_ctl && bus_wdata[0] && !busy;

  always_comb begin
    op_d   = op_q;
    addr_d = addr_q;
    data_d = data_q;
    if (wr_op)   op_d   = op_t'(bus_wdata[OP_W-1:0]);
    if (wr_addr) addr_d = bus_wdata;
    if (rd_done)      data_d = rd_word;
    else if (wr_data) data_d = bus_wdata;
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = data_q;
      2'd1:    bus_rdata = addr_q;
      2'd2:    bus_rdata = {{(WORD_W-OP_W){1'b0}}, op_q};
      default: bus_rdata = {{(WORD_W-1){1'b0}}, busy};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      op_q   <= op_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_master_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  op_t               op,
  input  logic [WORD_W-1:0] addr,
  input  logic [WORD_W-1:0] data,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              rd_done,
  output logic [WORD_W-1:0] rd_word
);
  localparam int IW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [IW-1:0]         idx_q, idx_d;
  logic [WORD_W-1:0]     rx_q, rx_d;
  logic                  busy_q, busy_d;
  logic                  rd_q, rd_d;
  logic                  last_bit;

  assign last_bit = busy_q && fall_tick && (idx_q == IW'(FRAME_BITS - 1));
  assign rd_done  = last_bit && rd_q;
  assign rd_word  = rx_q;
  assign busy     = busy_q;
  assign mdio_o   = busy_q ? sh_q[FRAME_BITS-1] : 1'b1;
  assign mdio_oe  = busy_q && !(rd_q && idx_q >= IW'(TA_POS));

  always_comb begin
    sh_d   = sh_q;
    idx_d  = idx_q;
    rx_d   = rx_q;
    busy_d = busy_q;
    rd_d   = rd_q;
    if (start) begin
      busy_d = 1'b1;
      sh_d   = build_frame(op, addr, data);
      idx_d  = '0;
      rd_d   = is_read(op);
    end else if (busy_q) begin
      if (rise_tick && rd_q && idx_q >= IW'(DATA_POS))
        rx_d = {rx_q[WORD_W-2:0], mdio_i};
      if (last_bit) begin
        busy_d = 1'b0;
      end else if (fall_tick) begin
        sh_d  = {sh_q[FRAME_BITS-2:0], 1'b1};
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      idx_q  <= '0;
      rx_q   <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      rx_q   <= rx_d;
      busy_q <= busy_d;
      rd_q   <= rd_d;
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_master_pkg::*;
#(
  parameter int CLK_DIV_HALF = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  op_t               op_w;
  logic [WORD_W-1:0] addr_w, data_w, rd_word_w;
  logic              start_w, busy_w, rd_done_w, rise_w, fall_w;

  mdio_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy_w),
    .rd_done(rd_done_w), .rd_word(rd_word_w), .op_q(op_w),
    .addr_q(addr_w), .data_q(data_w), .start(start_w)
  );

  mdio_clkgen #(.HALF(CLK_DIV_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy_w), .mdc(mdc),
    .rise_tick(rise_w), .fall_tick(fall_w)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_w), .op(op_w), .addr(addr_w),
    .data(data_w), .rise_tick(rise_w), .fall_tick(fall_w), .mdio_i(mdio_i),
    .busy(busy_w), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_done(rd_done_w),
    .rd_word(rd_word_w)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [1:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        busy,
  input logic        rd_done,
  input logic [15:0] data_q
);
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc));

  assert_start_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(bus_wr) && $past(bus_addr) == 2'd3 && $past(bus_wdata[0])));

  assert_end_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !mdc);

  assert_mdio_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o));

  assert_data_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(bus_wr) && $past(bus_addr) == 2'd0) && !$past(rd_done) |-> $stable(data_q));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy_w), .rd_done(rd_done_w), .data_q(data_w)
);

// File: tb/test_mdio_master.sv
module test_mdio_master;
  localparam int HALF = 3;

  logic        clk, rst_n, bus_wr, mdio_i;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        mdc, mdio_o, mdio_oe;

  int n_tests = 0, n_fail = 0;
  int nrise = 0, cyc = 0, last_rise = 0, per = 0;
  logic [63:0] seen, oes;
  logic [15:0] resp;
  bit          finished = 0;

  mdio_master #(.CLK_DIV_HALF(HALF)) i_mdio_master (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  initial clk = 0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  // PHY side model
  always @(posedge mdc) begin
    seen = {seen[62:0], mdio_o};
    oes  = {oes[62:0], mdio_oe};
    if (nrise > 0) per = cyc - last_rise;
    last_rise = cyc;
    nrise++;
  end
  always @(negedge mdc) begin
    if (nrise >= 48 && nrise < 64) mdio_i = resp[63-nrise];
    else mdio_i = 1'b1;
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic bit exp_read(bit c45, logic [1:0] opc);
    return c45 ? opc[1] : (opc == 2'b10);
  endfunction

  function automatic logic [63:0] exp_frame(bit c45, logic [1:0] opc, logic [4:0] port,
                                            logic [4:0] dev, logic [15:0] a, logic [15:0] d);
    logic [15:0] pay = (c45 && opc == 2'b00) ? a : d;
    return {32'hFFFF_FFFF, c45 ? 2'b00 : 2'b01, opc, port, dev, 2'b10, pay};
  endfunction

  task automatic run_frame(bit c45, logic [1:0] opc, logic [4:0] port, logic [4:0] dev,
                           logic [15:0] a, logic [15:0] d, logic [15:0] rsp, bit poke);
    logic [15:0] rv;
    logic [63:0] ef;
    bit rd;
    int guard;
    rd = exp_read(c45, opc);
    ef = exp_frame(c45, opc, port, dev, a, d);
    bus_write(2'd0, d);
    bus_write(2'd1, a);
    bus_write(2'd2, {3'b0, c45, opc, port, dev});
    nrise = 0; resp = rsp; mdio_i = 1; seen = '0; oes = '0;
    bus_write(2'd3, 16'h1);
    bus_read(2'd3, rv);
    chk(rv == 16'h1, "R2 busy after start", rv, 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      bus_write(2'd3, 16'h1);
    end
    guard = 0;
    do begin
      bus_read(2'd3, rv);
      guard++;
    end while (rv[0] && guard < 5000);
    chk(rv == 16'h0, "R2 busy clears", rv, 0);
    repeat (4 * HALF) @(negedge clk);
    chk(nrise == 64, "R3 one frame per start", nrise, 64);
    chk(per == 2 * HALF, "R10 mdc period", per, 2 * HALF);
    chk(mdc == 0, "R10 mdc idle low", mdc, 0);
    if (rd) begin
      chk(seen[63:18] == ef[63:18], "R4 R5 R6 read header", seen[63:18], ef[63:18]);
      chk(oes == {{46{1'b1}}, 18'b0}, "R9 release at turnaround", oes, {{46{1'b1}}, 18'b0});
      bus_read(2'd0, rv);
      chk(rv == rsp, "R9 read data captured", rv, rsp);
    end else begin
      chk(seen == ef, (c45 && opc == 2'b00) ? "R8 address frame" : "R7 write frame", seen, ef);
      chk(oes == '1, "R7 driven throughout", oes, '1);
    end
  endtask

  initial begin
    logic [15:0] rv;
    rst_n = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; mdio_i = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    bus_read(2'd3, rv);
    chk(rv == 0, "R1 control reset", rv, 0);
    chk(mdc == 0, "R1 mdc reset", mdc, 0);
    chk(mdio_oe == 0, "R1 oe reset", mdio_oe, 0);

    bus_write(2'd0, 16'hBEEF); bus_write(2'd1, 16'h1234); bus_write(2'd2, 16'hFFFF);
    bus_read(2'd0, rv); chk(rv == 16'hBEEF, "R11 data readback", rv, 16'hBEEF);
    bus_read(2'd1, rv); chk(rv == 16'h1234, "R11 addr readback", rv, 16'h1234);
    bus_read(2'd2, rv); chk(rv == 16'h1FFF, "R11 op readback", rv, 16'h1FFF);

    // directed: short write, short read, extended address/write/read
    run_frame(0, 2'b01, 5'h11, 5'h0A, 16'h5555, 16'hA5C3, 16'h0, 0);
    run_frame(0, 2'b10, 5'h03, 5'h1F, 16'h0000, 16'h0000, 16'h8001, 0);
    run_frame(1, 2'b00, 5'h1C, 5'h01, 16'h9002, 16'h7777, 16'h0, 1);
    run_frame(1, 2'b01, 5'h1C, 5'h01, 16'h9002, 16'h0F0F, 16'h0, 0);
    run_frame(1, 2'b11, 5'h00, 5'h03, 16'h0000, 16'h1111, 16'hC0DE, 1);
    run_frame(1, 2'b10, 5'h15, 5'h1E, 16'h0000, 16'h0000, 16'h7FFE, 0);

    void'($urandom(32'd4321));
    for (int i = 0; i < 8; i++) begin
      bit c45 = $urandom_range(1, 0);
      logic [1:0] opc = c45 ? 2'($urandom_range(3, 0)) : ($urandom_range(1, 0) ? 2'b01 : 2'b10);
      run_frame(c45, opc, 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom),
                16'($urandom), bit'($urandom_range(1, 0)));
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule